// File: doc/BRIEF.md
# Mode-Selected 4-Bit Arithmetic and Logic Unit

This block is a purely combinational slice of an arithmetic and logic unit. It takes two 4-bit operands, a 4-bit function select, a mode bit and an active-low carry input. It returns a 4-bit result, an active-low carry output, active-low group propagate and generate outputs for an external carry-lookahead unit, and a flag that is high whenever the result is all ones.

With the mode bit high, the select picks one of 16 bitwise logic functions, and the carry input has no effect on the result. With the mode bit low, the select picks one of 16 arithmetic functions. Each arithmetic function is the sum of two select-dependent operand words plus the carry, and that sum is formed by a carry that ripples through the four bit positions. Several slices can be chained: either the ripple carry goes straight from one slice to the next, or the group propagate and generate outputs feed a lookahead generator. In the select encodings below, sel[3] is the most significant bit. A bar (~) means bitwise NOT within the 4-bit word.

Top module: `alu4_core`

## Requirements
- R1: With logic_mode = 1, f for sel = 0 to 15 is, in order: ~a, ~(a|b), ~a&b, 0000, ~(a&b), ~b, a^b, a&~b, ~a|b, ~(a^b), b, a&b, 1111, a|~b, a|b, a.
- R2: With logic_mode = 1, the value of carry_in_n has no effect on f.
- R3: With logic_mode = 0 and carry_in_n = 1, f for sel = 0 to 15 is the low 4 bits of, in order: a, a|b, a|~b, 1111, a+(a&~b), (a|b)+(a&~b), a+~b (that is, a minus b minus 1), 1111+(a&~b), a+(a&b), a+b, (a|~b)+(a&b), 1111+(a&b), a+a, (a|b)+a, (a|~b)+a, 1111+a.
- R4: With logic_mode = 0 and carry_in_n = 0, f is the R3 result plus one, modulo 16.
- R5: carry_out_n is 0 exactly when the R3 sum plus the carry in (1 when carry_in_n = 0) is 16 or more. This holds in both modes.
- R6: Per bit i, the propagate term is a[i] | (b[i]&sel[0]) | (~b[i]&sel[1]) and the generate term is (a[i]&~b[i]&sel[2]) | (a[i]&b[i]&sel[3]). grp_prop_n is 0 exactly when all four propagate terms are 1. grp_gen_n is 0 exactly when a carry leaves bit 3 with no carry in, which means some generate term i is 1 and all propagate terms above i are 1.
- R7: a_eq_b is 1 exactly when f = 1111. With logic_mode = 0, sel = 0110 and carry_in_n = 1, it is therefore 1 exactly when a equals b.
- R8: The carry out agrees with the lookahead outputs. ~carry_out_n equals ~grp_gen_n | (~grp_prop_n & ~carry_in_n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| sel | input | 4 | Function select |
| logic_mode | input | 1 | 1 selects the logic functions, 0 selects the arithmetic functions |
| carry_in_n | input | 1 | Active-low carry into bit 0 |
| f | output | 4 | Result |
| carry_out_n | output | 1 | Active-low carry out of bit 3 |
| grp_prop_n | output | 1 | Active-low group propagate |
| grp_gen_n | output | 1 | Active-low group generate |
| a_eq_b | output | 1 | High when the result is all ones |

## Verification
The hardest cases to reach are the carry paths that run all the way through the slice. In these cases a carry entering bit 0 must travel through four propagating positions, which needs the propagate word to be 1111. That only happens for particular pairings of select and operands, such as the minus-one forms or a+~b with a equal to b. The bench therefore sweeps every mode, select, operand pair and carry-in value. This reaches each full-length propagate chain, each generate at bit 3 alone, and every equality case of the subtract form. The expected results are computed as integer sums of the operand pairs listed in the requirements.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  // Per-bit propagate term for the arithmetic operand word.
  function automatic logic prop_term(input logic ai, input logic bi, input logic [3:0] s);
    return ai | (bi & s[0]) | (~bi & s[1]);
  endfunction

  // Per-bit generate term (second arithmetic operand word).
  function automatic logic gen_term(input logic ai, input logic bi, input logic [3:0] s);
    return (ai & ~bi & s[2]) | (ai & bi & s[3]);
  endfunction

  // Full-adder style carry step.
  function automatic logic carry_step(input logic p, input logic g, input logic c);
    return g | (p & c);
  endfunction

endpackage

// File: rtl/alu4_bit_terms.sv
module alu4_bit_terms #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       sel,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen
);
  import alu4_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop[i] = prop_term(a[i], b[i], sel);
    assign gen[i]  = gen_term(a[i], b[i], sel);
  end

  // R6: a generate term never appears where the bit does not propagate
  always_comb begin
    gen_within_prop_chk: assert ((gen & ~prop) == '0);
  end

endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic             c_in,
  output logic [WIDTH:0]   carry
);
  import alu4_pkg::*;

  assign carry[0] = c_in;
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign carry[i+1] = carry_step(prop[i], gen[i], carry[i]);
  end

endmodule

// File: rtl/alu4_group_la.sv
module alu4_group_la #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  output logic             grp_p,
  output logic             grp_g
);
  import alu4_pkg::*;

  logic [WIDTH:0] g_acc;

  // Group generate accumulated from bit 0 upward with no carry in.
  assign g_acc[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_la
    assign g_acc[i+1] = carry_step(prop[i], gen[i], g_acc[i]);
  end

  assign grp_p = &prop;
  assign grp_g = g_acc[WIDTH];

  // R6: an all-propagating group must pass any carry, and with the
  // generate word empty no carry can be created
  always_comb begin
    grp_gen_needs_gen_chk: assert (!(grp_g && gen == '0));
  end

endmodule

// File: rtl/alu4_result.sv
module alu4_result #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic [WIDTH:0]   carry,
  input  logic             logic_mode,
  output logic [WIDTH-1:0] f,
  output logic             all_ones
);
  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] arith_f;

  assign half_sum = prop ^ gen;
  assign arith_f  = half_sum ^ carry[WIDTH-1:0];

  // Logic mode shows the inverted half sum; no carry enters it.
  assign f        = logic_mode ? ~half_sum : arith_f;
  assign all_ones = &f;

  // R3 R4: arithmetic result and carry out together form the full sum
  always_comb begin
    if (!logic_mode) begin
      arith_sum_chk: assert ({carry[WIDTH], f} ==
        ({1'b0, prop} + {1'b0, gen} + {{WIDTH{1'b0}}, carry[0]}));
    end
  end

endmodule

// File: rtl/alu4_core.sv
module alu4_core #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       sel,
  input  logic             logic_mode,
  input  logic             carry_in_n,
  output logic [WIDTH-1:0] f,
  output logic             carry_out_n,
  output logic             grp_prop_n,
  output logic             grp_gen_n,
  output logic             a_eq_b
);
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;
  logic [WIDTH:0]   carry;
  logic             grp_p;
  logic             grp_g;
  logic             c_in;

  assign c_in = ~carry_in_n;

  alu4_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .a    (a),
    .b    (b),
    .sel  (sel),
    .prop (prop),
    .gen  (gen)
  );

  alu4_ripple #(.WIDTH(WIDTH)) u_ripple (
    .prop  (prop),
    .gen   (gen),
    .c_in  (c_in),
    .carry (carry)
  );

  alu4_group_la #(.WIDTH(WIDTH)) u_la (
    .prop  (prop),
    .gen   (gen),
    .grp_p (grp_p),
    .grp_g (grp_g)
  );

  alu4_result #(.WIDTH(WIDTH)) u_res (
    .prop       (prop),
    .gen        (gen),
    .carry      (carry),
    .logic_mode (logic_mode),
    .f          (f),
    .all_ones   (a_eq_b)
  );

  assign carry_out_n = ~carry[WIDTH];
  assign grp_prop_n  = ~grp_p;
  assign grp_gen_n   = ~grp_g;

  always_comb begin
    // R8
    la_vs_ripple_chk: assert (~carry_out_n == (~grp_gen_n | (~grp_prop_n & ~carry_in_n)));
    // R1
    if (logic_mode && sel == 4'b1110) logic_or_chk: assert (f == (a | b));
    // R1
    if (logic_mode && sel == 4'b0110) logic_xor_chk: assert (f == (a ^ b));
    // R7
    if (!logic_mode && sel == 4'b0110 && carry_in_n)
      equal_flag_chk: assert (a_eq_b == (a == b));
  end

endmodule

// File: tb/alu4_core_tb.sv
module alu4_core_tb;
  logic       clk = 1'b0;
  logic [3:0] a, b, sel;
  logic       logic_mode, carry_in_n;
  logic [3:0] f;
  logic       carry_out_n, grp_prop_n, grp_gen_n, a_eq_b;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  alu4_core u_dut (
    .a(a), .b(b), .sel(sel), .logic_mode(logic_mode), .carry_in_n(carry_in_n),
    .f(f), .carry_out_n(carry_out_n), .grp_prop_n(grp_prop_n),
    .grp_gen_n(grp_gen_n), .a_eq_b(a_eq_b)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s m=%0d s=%0d a=%0d b=%0d cn=%0d actual=%0d expected=%0d",
               req, logic_mode, sel, a, b, carry_in_n, act, exp);
    end
  endtask

  function automatic int logic_ref(int s, int x, int y);
    int nx = ~x & 15, ny = ~y & 15;
    case (s)
      0: return nx;            1: return ~(x | y) & 15;
      2: return nx & y;        3: return 0;
      4: return ~(x & y) & 15; 5: return ny;
      6: return x ^ y;         7: return x & ny;
      8: return nx | y;        9: return ~(x ^ y) & 15;
      10: return y;            11: return x & y;
      12: return 15;           13: return x | ny;
      14: return x | y;        default: return x;
    endcase
  endfunction

  // Sum of the two operand words listed in R3, without carry.
  function automatic int arith_ref(int s, int x, int y);
    int ny = ~y & 15;
    case (s)
      0: return x;                 1: return x | y;
      2: return x | ny;            3: return 15;
      4: return x + (x & ny);      5: return (x | y) + (x & ny);
      6: return x + ny;            7: return 15 + (x & ny);
      8: return x + (x & y);       9: return x + y;
      10: return (x | ny) + (x & y); 11: return 15 + (x & y);
      12: return x + x;            13: return (x | y) + x;
      14: return (x | ny) + x;     default: return 15 + x;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++)
            for (int cn = 0; cn < 2; cn++) begin
              int base, cin, sum, ef, pw, pexp, gexp;
              @(negedge clk);
              logic_mode = m[0]; sel = s[3:0]; a = x[3:0]; b = y[3:0];
              carry_in_n = cn[0];
              #2;
              base = arith_ref(s, x, y);
              cin  = (cn == 0) ? 1 : 0;
              sum  = base + cin;
              if (m == 1) begin
                ef = logic_ref(s, x, y);
                if (cn == 1) check("R1", f, ef);
                else         check("R2", f, ef);
              end else begin
                ef = sum & 15;
                if (cn == 1) check("R3", f, ef);
                else         check("R4", f, ef);
              end
              check("R5", carry_out_n, (sum >= 16) ? 0 : 1);
              pw = (x | (s[0] ? y : 0) | (s[1] ? (~y & 15) : 0)) & 15;
              pexp = (pw == 15) ? 0 : 1;
              gexp = (base >= 16) ? 0 : 1;
              check("R6 prop", grp_prop_n, pexp);
              check("R6 gen", grp_gen_n, gexp);
              check("R7", a_eq_b, (ef == 15) ? 1 : 0);
              if (m == 0 && s == 6 && cn == 1)
                check("R7 equality", a_eq_b, (x == y) ? 1 : 0);
              check("R8", carry_out_n,
                    ((grp_gen_n == 0) || (grp_prop_n == 0 && cn == 0)) ? 0 : 1);
            end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule